// File: doc/BRIEF.md
# PLL Power-Up and Lock Sequencer

This block steps a clock-multiplier PLL inside a frequency synthesizer through a fixed bring-up order and a fixed shutdown order. The analog PLL is not part of it: the block drives the PLL's block-reset, reference-bandwidth, feedback-divider and power-down controls, and takes the lock indication as an input. A one-cycle `en_req` starts bring-up and a one-cycle `dis_req` starts shutdown. The feedback divider code is captured from `div_code_i` when the enable request is accepted.

Bring-up has these steps in order. The block reset is released. The bandwidth filter is set to code 0, the "good reference" code. The divider code is loaded. The PLL is powered up. The block then waits for lock, and if lock is not seen within a 10 ms cycle budget it ends with a timeout error. Shutdown powers the PLL down first and only then asserts the block reset. The reset, bandwidth and lock-wait steps can each be removed by a parameter. The level of the power-down control is set by a polarity parameter.

The states are ST_IDLE, ST_RST_REL, ST_BW_SET, ST_DIV_LOAD, ST_PWR_UP, ST_LOCK_WAIT, ST_PWR_DN, ST_RST_SET, ST_DONE and ST_FAIL. The transitions are as follows:
- ST_IDLE goes to the first present enable step on `en_req`, or to ST_PWR_DN on `dis_req`. Enable wins if both are high.
- ST_RST_REL goes to ST_BW_SET, or to ST_DIV_LOAD when there is no bandwidth step.
- ST_BW_SET goes to ST_DIV_LOAD, and ST_DIV_LOAD goes to ST_PWR_UP.
- ST_PWR_UP goes to ST_LOCK_WAIT, or to ST_DONE when there is no lock step.
- ST_LOCK_WAIT goes to ST_DONE on lock, or to ST_FAIL when the budget is used up.
- ST_PWR_DN goes to ST_RST_SET, or to ST_DONE when there is no reset step. ST_RST_SET goes to ST_DONE.
- ST_DONE and ST_FAIL go back to ST_IDLE.

Top module: `pll_pwr_seq`

## Requirements
- R1: After an accepted enable, each present step takes effect one clock later than the step before it, in this order: `blk_rst_n_o` rises, `bw_sel_o` becomes 0, `div_code_o` takes the captured code, and the PLL is powered up. The first step takes effect two clocks after the accepting edge.
- R2: `bw_sel_o` is 1 (very bad reference) after reset. The enable sequence only ever writes 0 (good reference) to it. The codes are good=0, very bad=1, bad=2 and very good=3.
- R3: In ST_LOCK_WAIT, lock sampled high at a clock edge raises `done_o` for exactly one cycle after that edge.
- R4: If lock is not sampled high in TMO = CLK_HZ/100 consecutive ST_LOCK_WAIT cycles, `tmo_err_o` pulses for one cycle, TMO clocks after power-up becomes visible, and `done_o` is not raised.
- R5: On an accepted disable, `pwrdn_o` goes to the power-down level two clocks after the accepting edge, while `blk_rst_n_o` is still high. `blk_rst_n_o` falls one clock later, together with `done_o`.
- R6: With PWR_POL=1, `pwrdn_o` is 0 when powered up and 1 when powered down. With PWR_POL=0 the levels are swapped. `pwrdn_o` changes only while a sequence is running.
- R7: `pll_on_o` is high exactly when `pwrdn_o` differs from PWR_POL.
- R8: When HAS_RESET, HAS_BW or HAS_LOCK is 0, its step takes no cycle. `blk_rst_n_o` is then held at 1, `bw_sel_o` keeps its reset code, and `done_o` follows power-up directly.
- R9: An `en_req` or `dis_req` that arrives while `busy_o` is high has no effect on any output.
- R10: After reset the outputs are as follows: `busy_o`, `done_o` and `tmo_err_o` are 0; `div_code_o` is 0; `pwrdn_o` equals PWR_POL; `blk_rst_n_o` is 0 when HAS_RESET=1.
- R11: `busy_o` rises one clock after the accepting edge. It stays high through the `done_o` or `tmo_err_o` cycle and falls in the following cycle.
- R12: The divider code loaded is the value of `div_code_i` at the accepting edge. Later changes to `div_code_i` do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Start the bring-up sequence |
| dis_req | input | 1 | Start the shutdown sequence |
| div_code_i | input | DIV_W | Feedback divider code, captured when enable is accepted |
| pll_lock_i | input | 1 | Lock indication from the PLL |
| blk_rst_n_o | output | 1 | Active-low reset to the synthesizer block |
| bw_sel_o | output | 2 | Reference-bandwidth filter code |
| div_code_o | output | DIV_W | Feedback divider code driven to the PLL |
| pwrdn_o | output | 1 | Power-down control, level set by PWR_POL |
| pll_on_o | output | 1 | PLL powered up, decoded from pwrdn_o |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse when a sequence completes |
| tmo_err_o | output | 1 | One-cycle pulse when lock timed out |

## Verification
The bench checks the step order cycle by cycle on the way up and on the way down.
- A design that merged two steps into one cycle, or swapped two steps, would show the wrong level at one of the sampled points.
- A design that asserted reset before powering down would drop `blk_rst_n_o` while `pll_on_o` is still high.

The timeout is measured to the exact cycle, which catches an off-by-one budget.

A disable and a second enable are injected during the lock wait. A design that did not ignore them would power down or reload the divider mid-sequence.

A second instance, with all optional steps removed and the opposite power polarity, shows whether skipped steps cost cycles or disturb the unused controls.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_REL,
        ST_BW_SET,
        ST_DIV_LOAD,
        ST_PWR_UP,
        ST_LOCK_WAIT,
        ST_PWR_DN,
        ST_RST_SET,
        ST_DONE,
        ST_FAIL
    } seq_state_e;

    localparam int BW_W = 2;
    localparam logic [BW_W-1:0] BW_GOOD  = 2'd0;
    localparam logic [BW_W-1:0] BW_VBAD  = 2'd1;
    localparam logic [BW_W-1:0] BW_BAD   = 2'd2;
    localparam logic [BW_W-1:0] BW_VGOOD = 2'd3;

endpackage

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter bit HAS_RESET = 1'b1,
    parameter bit HAS_BW    = 1'b1,
    parameter bit HAS_LOCK  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic       lock_i,
    input  logic       expired_i,
    output seq_state_e state_o,
    output logic       accept_en_o
);

    seq_state_e state_q, state_d;

    // The first enable step and the step after reset release both depend
    // on which optional steps are present.
    localparam seq_state_e EN_FIRST  = HAS_RESET ? ST_RST_REL
                                     : (HAS_BW ? ST_BW_SET : ST_DIV_LOAD);
    localparam seq_state_e AFTER_REL = HAS_BW ? ST_BW_SET : ST_DIV_LOAD;
    localparam seq_state_e AFTER_UP  = HAS_LOCK ? ST_LOCK_WAIT : ST_DONE;
    localparam seq_state_e AFTER_DN  = HAS_RESET ? ST_RST_SET : ST_DONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_req)       state_d = EN_FIRST;
                else if (dis_req) state_d = ST_PWR_DN;
            end
            ST_RST_REL:   state_d = AFTER_REL;
            ST_BW_SET:    state_d = ST_DIV_LOAD;
            ST_DIV_LOAD:  state_d = ST_PWR_UP;
            ST_PWR_UP:    state_d = AFTER_UP;
            ST_LOCK_WAIT: begin
                if (lock_i)         state_d = ST_DONE;
                else if (expired_i) state_d = ST_FAIL;
            end
            ST_PWR_DN:    state_d = AFTER_DN;
            ST_RST_SET:   state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAIL:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign state_o     = state_q;
    assign accept_en_o = (state_q == ST_IDLE) && en_req;

endmodule

// File: rtl/pll_seq_lock_timer.sv
module pll_seq_lock_timer #(
    parameter int unsigned TMO_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned CNT_W = $clog2(TMO_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // Counts the cycles spent waiting. It clears whenever the wait is
    // not running, so every wait gets the full budget.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (!run_i) cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int DIV_W     = 3,
    parameter bit HAS_RESET = 1'b1,
    parameter bit PWR_POL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_state_e       state_i,
    input  logic             accept_en_i,
    input  logic [DIV_W-1:0] div_code_i,
    output logic             blk_rst_n_o,
    output logic [BW_W-1:0]  bw_sel_o,
    output logic [DIV_W-1:0] div_code_o,
    output logic             pwrdn_o
);

    // Without reset control the block reset is never driven low.
    localparam logic RST_INIT = HAS_RESET ? 1'b0 : 1'b1;

    logic [DIV_W-1:0] div_hold_q;

    // Output process: each state applies its own control action.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_hold_q  <= '0;
            blk_rst_n_o <= RST_INIT;
            bw_sel_o    <= BW_VBAD;
            div_code_o  <= '0;
            pwrdn_o     <= PWR_POL;
        end else begin
            if (accept_en_i) div_hold_q <= div_code_i;
            unique case (state_i)
                ST_RST_REL:  blk_rst_n_o <= 1'b1;
                ST_BW_SET:   bw_sel_o    <= BW_GOOD;
                ST_DIV_LOAD: div_code_o  <= div_hold_q;
                ST_PWR_UP:   pwrdn_o     <= !PWR_POL;
                ST_PWR_DN:   pwrdn_o     <= PWR_POL;
                ST_RST_SET:  blk_rst_n_o <= 1'b0;
                default:     ;
            endcase
        end
    end

endmodule

// File: rtl/pll_pwr_seq.sv
module pll_pwr_seq
    import pll_seq_pkg::*;
#(
    parameter int          DIV_W     = 3,
    parameter int unsigned CLK_HZ    = 50000000,
    parameter bit          HAS_RESET = 1'b1,
    parameter bit          HAS_BW    = 1'b1,
    parameter bit          HAS_LOCK  = 1'b1,
    parameter bit          PWR_POL   = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_req,
    input  logic             dis_req,
    input  logic [DIV_W-1:0] div_code_i,
    input  logic             pll_lock_i,
    output logic             blk_rst_n_o,
    output logic [1:0]       bw_sel_o,
    output logic [DIV_W-1:0] div_code_o,
    output logic             pwrdn_o,
    output logic             pll_on_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             tmo_err_o
);

    // The lock budget is 10 ms of clock cycles, with at least one cycle.
    localparam int unsigned TMO_RAW    = CLK_HZ / 100;
    localparam int unsigned TMO_CYCLES = (TMO_RAW < 1) ? 1 : TMO_RAW;

    seq_state_e state;
    logic       accept_en;
    logic       expired;

    pll_seq_fsm #(
        .HAS_RESET (HAS_RESET),
        .HAS_BW    (HAS_BW),
        .HAS_LOCK  (HAS_LOCK)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_req      (en_req),
        .dis_req     (dis_req),
        .lock_i      (pll_lock_i),
        .expired_i   (expired),
        .state_o     (state),
        .accept_en_o (accept_en)
    );

    pll_seq_lock_timer #(
        .TMO_CYCLES (TMO_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (state == ST_LOCK_WAIT),
        .expired_o (expired)
    );

    pll_seq_ctrl #(
        .DIV_W     (DIV_W),
        .HAS_RESET (HAS_RESET),
        .PWR_POL   (PWR_POL)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .accept_en_i (accept_en),
        .div_code_i  (div_code_i),
        .blk_rst_n_o (blk_rst_n_o),
        .bw_sel_o    (bw_sel_o),
        .div_code_o  (div_code_o),
        .pwrdn_o     (pwrdn_o)
    );

    assign pll_on_o  = (pwrdn_o != PWR_POL);
    assign busy_o    = (state != ST_IDLE);
    assign done_o    = (state == ST_DONE);
    assign tmo_err_o = (state == ST_FAIL);

endmodule

// File: rtl/pll_pwr_seq_chk.sv
module pll_pwr_seq_chk #(
    parameter int DIV_W     = 3,
    parameter bit HAS_RESET = 1'b1,
    parameter bit HAS_BW    = 1'b1,
    parameter bit PWR_POL   = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pll_lock_i,
    input logic             blk_rst_n_o,
    input logic [1:0]       bw_sel_o,
    input logic [DIV_W-1:0] div_code_o,
    input logic             pwrdn_o,
    input logic             pll_on_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             tmo_err_o
);

    // R1
    pwrup_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_on_o) |-> ((!HAS_RESET || blk_rst_n_o) && (!HAS_BW || bw_sel_o == 2'd0)));

    // R5
    pwrdn_before_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_rst_n_o) |-> (!pll_on_o && $past(!pll_on_o)));

    // R6
    pwr_moves_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwrdn_o) |-> $past(busy_o));

    // R11
    busy_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && !tmo_err_o) |=> busy_o);

    // R4
    tmo_without_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err_o |-> $past(!pll_lock_i));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    on_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(pwrdn_o) |-> $changed(pll_on_o));

    // R12
    div_stable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(div_code_o));

endmodule

bind pll_pwr_seq pll_pwr_seq_chk #(
    .DIV_W     (DIV_W),
    .HAS_RESET (HAS_RESET),
    .HAS_BW    (HAS_BW),
    .PWR_POL   (PWR_POL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_lock_i  (pll_lock_i),
    .blk_rst_n_o (blk_rst_n_o),
    .bw_sel_o    (bw_sel_o),
    .div_code_o  (div_code_o),
    .pwrdn_o     (pwrdn_o),
    .pll_on_o    (pll_on_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .tmo_err_o   (tmo_err_o)
);

// File: tb/pll_pwr_seq_tb_top.sv
module pll_pwr_seq_tb_top;

    localparam int DIV_W  = 3;
    localparam int CLK_HZ = 3200;
    localparam int TMO    = CLK_HZ / 100;

    typedef struct {
        bit         is_err;
        bit         on;
        logic [2:0] div;
    } exp_t;

    exp_t exp_q[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    // Instance A: all steps, PWR_POL=1
    logic en_a = 0, dis_a = 0, lock_a = 0;
    logic [DIV_W-1:0] div_in_a = '0;
    logic blk_a, pwrdn_a, on_a, busy_a, done_a, err_a;
    logic [1:0] bw_a;
    logic [DIV_W-1:0] div_a;

    // Instance B: no optional steps, PWR_POL=0
    logic en_b = 0, dis_b = 0;
    logic [DIV_W-1:0] div_in_b = '0;
    logic blk_b, pwrdn_b, on_b, busy_b, done_b, err_b;
    logic [1:0] bw_b;
    logic [DIV_W-1:0] div_b;

    pll_pwr_seq #(.DIV_W(DIV_W), .CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_req(en_a), .dis_req(dis_a),
        .div_code_i(div_in_a), .pll_lock_i(lock_a),
        .blk_rst_n_o(blk_a), .bw_sel_o(bw_a), .div_code_o(div_a),
        .pwrdn_o(pwrdn_a), .pll_on_o(on_a), .busy_o(busy_a),
        .done_o(done_a), .tmo_err_o(err_a)
    );

    pll_pwr_seq #(.DIV_W(DIV_W), .CLK_HZ(CLK_HZ), .HAS_RESET(1'b0),
                  .HAS_BW(1'b0), .HAS_LOCK(1'b0), .PWR_POL(1'b0)) dut2_i (
        .clk(clk), .rst_n(rst_n), .en_req(en_b), .dis_req(dis_b),
        .div_code_i(div_in_b), .pll_lock_i(1'b0),
        .blk_rst_n_o(blk_b), .bw_sel_o(bw_b), .div_code_o(div_b),
        .pwrdn_o(pwrdn_b), .pll_on_o(on_b), .busy_o(busy_b),
        .done_o(done_b), .tmo_err_o(err_b)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic negs(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: pops an expected outcome on each completion of instance A
    always @(negedge clk) begin
        if (rst_n && (done_a || err_a)) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected completion", {30'd0, done_a, err_a}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R3/R4 outcome kind", {31'd0, err_a}, {31'd0, e.is_err});
                chk("R3/R4 done pulse", {31'd0, done_a}, {31'd0, !e.is_err});
                chk("R7 power state at end", {31'd0, on_a}, {31'd0, e.on});
                chk("R12 divider at end", {29'd0, div_a}, {29'd0, e.div});
            end
        end
    end

    task automatic push_exp(input bit is_err, input bit on, input logic [2:0] div);
        exp_t e;
        e.is_err = is_err; e.on = on; e.div = div;
        exp_q.push_back(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int k;
        negs(3);
        // R10 reset state
        chk("R10 blk reset", {31'd0, blk_a}, 32'd0);
        chk("R10 pwrdn", {31'd0, pwrdn_a}, 32'd1);
        chk("R10 busy/done/err", {29'd0, busy_a, done_a, err_a}, 32'd0);
        chk("R10 div", {29'd0, div_a}, 32'd0);
        chk("R2 bw reset code", {30'd0, bw_a}, 32'd1);
        rst_n = 1'b1;
        negs(2);

        // Enable with lock: R1 R2 R6 R7 R11 R12 R3
        en_a = 1; div_in_a = 3'd5;
        push_exp(1'b0, 1'b1, 3'd5);
        @(negedge clk); en_a = 0; div_in_a = 3'd2;
        chk("R11 busy after accept", {31'd0, busy_a}, 32'd1);
        chk("R1 reset not yet released", {31'd0, blk_a}, 32'd0);
        @(negedge clk);
        chk("R1 reset released first", {31'd0, blk_a}, 32'd1);
        chk("R1 bw not yet", {30'd0, bw_a}, 32'd1);
        @(negedge clk);
        chk("R2 bw good code", {30'd0, bw_a}, 32'd0);
        chk("R1 div not yet", {29'd0, div_a}, 32'd0);
        @(negedge clk);
        chk("R12 captured divider", {29'd0, div_a}, 32'd5);
        chk("R1 power not yet", {31'd0, pwrdn_a}, 32'd1);
        @(negedge clk);
        chk("R6 pol1 powered up is 0", {31'd0, pwrdn_a}, 32'd0);
        chk("R7 on decode", {31'd0, on_a}, 32'd1);
        lock_a = 1;
        @(negedge clk);
        chk("R3 done after lock", {31'd0, done_a}, 32'd1);
        chk("R11 busy in done", {31'd0, busy_a}, 32'd1);
        @(negedge clk);
        chk("R3 done single", {31'd0, done_a}, 32'd0);
        chk("R11 busy falls", {31'd0, busy_a}, 32'd0);
        lock_a = 0;

        // Disable: R5
        dis_a = 1;
        push_exp(1'b0, 1'b0, 3'd5);
        @(negedge clk); dis_a = 0;
        chk("R5 no change yet", {31'd0, pwrdn_a}, 32'd0);
        @(negedge clk);
        chk("R5 powered down", {31'd0, pwrdn_a}, 32'd1);
        chk("R5 reset still released", {31'd0, blk_a}, 32'd1);
        @(negedge clk);
        chk("R5 reset asserted", {31'd0, blk_a}, 32'd0);
        chk("R5 done with reset", {31'd0, done_a}, 32'd1);
        negs(2);

        // Timeout: R4
        en_a = 1; div_in_a = 3'd3;
        push_exp(1'b1, 1'b1, 3'd3);
        @(negedge clk); en_a = 0;
        k = 0;
        while (!on_a && k < 20) begin @(negedge clk); k++; end
        chk("R1 power-up latency", k, 32'd4);
        k = 0;
        while (!err_a && k < TMO + 10) begin @(negedge clk); k++; end
        chk("R4 timeout cycle count", k, TMO);
        negs(2);

        // Requests ignored while busy: R9
        en_a = 1; div_in_a = 3'd6;
        push_exp(1'b0, 1'b1, 3'd6);
        @(negedge clk); en_a = 0;
        negs(6);
        dis_a = 1; @(negedge clk); dis_a = 0;
        en_a = 1; div_in_a = 3'd1; @(negedge clk); en_a = 0;
        negs(2);
        chk("R9 disable ignored", {31'd0, pwrdn_a}, 32'd0);
        chk("R9 reset untouched", {31'd0, blk_a}, 32'd1);
        chk("R9 still busy", {31'd0, busy_a}, 32'd1);
        lock_a = 1;
        negs(3);
        lock_a = 0;
        chk("R9 divider kept", {29'd0, div_a}, 32'd6);
        chk("R9 idle after", {31'd0, busy_a}, 32'd0);
        chk("R3 queue drained", exp_q.size(), 32'd0);

        // Instance B: skipped steps and polarity 0: R8 R6
        chk("R8 blk held high", {31'd0, blk_b}, 32'd1);
        chk("R6 pol0 down level", {31'd0, pwrdn_b}, 32'd0);
        en_b = 1; div_in_b = 3'd4;
        @(negedge clk); en_b = 0;
        @(negedge clk);
        chk("R8 divider first", {29'd0, div_b}, 32'd4);
        @(negedge clk);
        chk("R6 pol0 up level", {31'd0, pwrdn_b}, 32'd1);
        chk("R8 done after power-up", {31'd0, done_b}, 32'd1);
        chk("R8 bw untouched", {30'd0, bw_b}, 32'd1);
        chk("R8 blk still high", {31'd0, blk_b}, 32'd1);
        negs(2);
        dis_b = 1; @(negedge clk); dis_b = 0;
        @(negedge clk);
        chk("R8 powered down", {31'd0, pwrdn_b}, 32'd0);
        chk("R8 done without reset step", {31'd0, done_b}, 32'd1);
        chk("R8 no timeout", {31'd0, err_b}, 32'd0);
        negs(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule